// File: doc/BRIEF.md
# Digital Input Interrupt Controller

This block watches a bank of digital input channels and drives one shared, active-low interrupt request. Every input first passes through a two-flop synchronizer. Software picks the detection mode for each channel. In edge mode, any change of the synchronized input raises that channel's pending bit. In level mode, the pending bit is raised whenever the input equals a programmed level. Only enabled channels can raise pending bits.

Software uses a small word-wide register port to reach the per-channel enable, mode, level and pending registers, and to reach a single interrupt vector. The vector appears on a dedicated output while the host runs its acknowledge cycle. The request stays asserted until software clears every enabled pending bit with write-one-to-clear accesses.

Top module: `din_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending, enable, mode and level registers and the vector all read 0, and `irq_n` is 1.
- R2: Register addresses are 0 = pending, 1 = enable, 2 = mode, 3 = level, 4 = vector (held in the low VEC_W bits). `rd_data` shows the addressed register in the same cycle. A write to addresses 1 to 4 is visible after the next rising edge.
- R3: A channel with mode bit 1 is an edge channel. A rising or a falling input change sets its pending bit. A value sampled on `din` at rising edge k is compared with the sample taken one edge earlier, and the pending bit is set at edge k+2.
- R4: A channel with mode bit 0 is a level channel. Its pending bit is set on every edge at which the synchronized input equals its level bit (1 = high, 0 = low).
- R5: A channel whose enable bit is 0 never sets its pending bit.
- R6: Writing 1 to a pending bit at address 0 clears it. Writing 0 leaves it unchanged.
- R7: If an event and a clearing write hit the same channel in the same cycle, the pending bit stays 1. So a level channel whose input still matches cannot be cleared.
- R8: `irq_n` is 0 exactly when some pending bit is 1 and its enable bit is also 1.
- R9: `vec_out` equals the vector register while `iack` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NCH | Asynchronous input channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | NCH | Register write data |
| rd_data | output | NCH | Data of the addressed register |
| iack | input | 1 | Interrupt acknowledge cycle in progress |
| vec_out | output | VEC_W | Vector presented during acknowledge |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
Two things can land on the same pending bit in one cycle: a detected event and a write-one-to-clear. The bench provokes this in two ways. It issues the clear on the exact cycle in which a delayed edge event reaches detection. It also clears a level channel whose input still matches. In both cases it expects the bit to read back as 1, and it expects the bit to drop only when a later clear meets no event. Random phases mix clears with input toggles. A cycle-level model of the requirements judges every readback and every `irq_n` value in those phases.

// File: rtl/din_irq_pkg.sv
// Shared definitions for the digital input interrupt controller.
// Assumes a 3-bit register address space.
package din_irq_pkg;
    typedef enum logic [2:0] {
        A_PEND  = 3'd0,
        A_ENA   = 3'd1,
        A_MODE  = 3'd2,
        A_LEVEL = 3'd3,
        A_VEC   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/din_sync.sv
// Two-flop synchronizer for each input channel.
// Assumes: inputs are asynchronous to clk; the reset value is 0.
module din_sync #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] dsync
);
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            logic meta_q, sync_q;
            // Two-stage capture of one channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                end else begin
                    meta_q <= din[g];
                    sync_q <= meta_q;
                end
            end
            assign dsync[g] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/din_detect.sv
// Per-channel event detection. Edge channels compare the current synchronized
// sample with the previous one. Level channels compare the sample with the
// programmed level. Results are gated by the enable bits.
// Assumes: dsync is already synchronous to clk.
module din_detect #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dsync,
    input  logic [NCH-1:0] enable,
    input  logic [NCH-1:0] mode,
    input  logic [NCH-1:0] level,
    output logic [NCH-1:0] evt
);
    logic [NCH-1:0] prev_q;

    // Holds the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= dsync;
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            logic edge_hit, level_hit;
            assign edge_hit  = dsync[g] ^ prev_q[g];
            assign level_hit = ~(dsync[g] ^ level[g]);
            // Selects the detection mode of this channel.
            always_comb begin
                evt[g] = enable[g] & (mode[g] ? edge_hit : level_hit);
            end
        end
    endgenerate
endmodule

// File: rtl/din_irq_regs.sv
// Register file: enable, mode, level, vector, and write-one-to-clear pending
// bits. A new event takes priority over a clear in the same cycle.
// Assumes: VEC_W <= NCH; reads are combinational.
module din_irq_regs
    import din_irq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [NCH-1:0]   wr_data,
    input  logic [NCH-1:0]   evt,
    output logic [NCH-1:0]   pend,
    output logic [NCH-1:0]   enable,
    output logic [NCH-1:0]   mode,
    output logic [NCH-1:0]   level,
    output logic [VEC_W-1:0] vec,
    output logic [NCH-1:0]   rd_data
);
    logic [NCH-1:0] clr;

    // Decodes the clear mask of a write to the pending register.
    always_comb begin
        clr = (wr_en && addr == A_PEND) ? wr_data : '0;
    end

    // Updates the pending bits: keep, clear on write-one, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | evt;
    end

    // Writes the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            mode   <= '0;
            level  <= '0;
            vec    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_ENA:   enable <= wr_data;
                A_MODE:  mode   <= wr_data;
                A_LEVEL: level  <= wr_data;
                A_VEC:   vec    <= wr_data[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_PEND:  rd_data = pend;
            A_ENA:   rd_data = enable;
            A_MODE:  rd_data = mode;
            A_LEVEL: rd_data = level;
            A_VEC:   rd_data = NCH'(vec);
            default: rd_data = '0;
        endcase
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & $past(clr) & ~$past(evt)) == '0));                          // R6
    AST_NO_SPURIOUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend & $past(pend) & ~$past(clr)) == '0));                        // R6
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend & $past(evt)) == '0));                                       // R7
    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(enable)) == '0));                     // R5
endmodule

// File: rtl/din_irq_ctrl.sv
// Top level of the digital input interrupt controller: synchronizer, detector
// and register file. Drives one shared active-low request and presents the
// vector during acknowledge.
// Assumes: a single clock domain for the register port; VEC_W <= NCH.
module din_irq_ctrl #(
    parameter int NCH   = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   din,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [NCH-1:0]   wr_data,
    output logic [NCH-1:0]   rd_data,
    input  logic             iack,
    output logic [VEC_W-1:0] vec_out,
    output logic             irq_n
);
    logic [NCH-1:0]   dsync, evt, pend, enable, mode, level;
    logic [VEC_W-1:0] vec;

    din_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(din), .dsync(dsync)
    );

    din_detect #(.NCH(NCH)) u_detect (
        .clk(clk), .rst_n(rst_n), .dsync(dsync), .enable(enable),
        .mode(mode), .level(level), .evt(evt)
    );

    din_irq_regs #(.NCH(NCH), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .evt(evt), .pend(pend), .enable(enable),
        .mode(mode), .level(level), .vec(vec), .rd_data(rd_data)
    );

    // Forms the shared request and the acknowledge vector.
    always_comb begin
        irq_n   = ~(|(pend & enable));
        vec_out = iack ? vec : '0;
    end

    AST_RELEASE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(wr_en));                                      // R8
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(evt) != '0 || $past(wr_en)));                // R8
endmodule

// File: tb/din_irq_ctrl_bench.sv
module din_irq_ctrl_bench;
    localparam int NCH = 8;
    localparam int VEC_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] din;
    logic wr_en;
    logic [2:0] addr;
    logic [NCH-1:0] wr_data;
    logic [NCH-1:0] rd_data;
    logic iack;
    logic [VEC_W-1:0] vec_out;
    logic irq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // model state
    logic [NCH-1:0] m_s1, m_s2, m_prev, m_pend, m_ena, m_mode, m_lvl;
    logic [VEC_W-1:0] m_vec;
    logic m_ack;

    din_irq_ctrl #(.NCH(NCH), .VEC_W(VEC_W)) u_din_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .iack(iack),
        .vec_out(vec_out), .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_pend;
            3'd1: return m_ena;
            3'd2: return m_mode;
            3'd3: return m_lvl;
            3'd4: return NCH'(m_vec);
            default: return '0;
        endcase
    endfunction

    function automatic logic [NCH-1:0] exp_evt();
        return m_ena & ((m_mode & (m_s2 ^ m_prev)) | (~m_mode & ~(m_s2 ^ m_lvl)));
    endfunction

    // One clock: drive at negedge, update model at the edge, compare after it.
    task automatic step(input logic [NCH-1:0] d, input logic w, input logic [2:0] a,
                        input logic [NCH-1:0] wd, input logic ack, input string tag);
        logic [NCH-1:0] ev, clr;
        @(negedge clk);
        din = d; wr_en = w; addr = a; wr_data = wd; iack = ack;
        ev  = exp_evt();
        clr = (w && a == 3'd0) ? wd : '0;
        @(posedge clk);
        m_pend = (m_pend & ~clr) | ev;
        if (w) begin
            case (a)
                3'd1: m_ena  = wd;
                3'd2: m_mode = wd;
                3'd3: m_lvl  = wd;
                3'd4: m_vec  = wd[VEC_W-1:0];
                default: ;
            endcase
        end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = d; m_ack = ack;
        #2;
        chk(rd_data == exp_read(a), tag, rd_data, exp_read(a));
        chk(irq_n == ~(|(m_pend & m_ena)), "R8", irq_n, ~(|(m_pend & m_ena)));
        chk(vec_out == (m_ack ? m_vec : '0), "R9", vec_out, (m_ack ? m_vec : 8'h0));
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [NCH-1:0] d;
        rst_n = 1'b0; din = '0; wr_en = 0; addr = 0; wr_data = 0; iack = 0;
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_ena = 0; m_mode = 0;
        m_lvl = 0; m_vec = 0; m_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            @(negedge clk); addr = 3'(a); #1;
            chk(rd_data == '0, "R1", rd_data, 0);
        end
        chk(irq_n == 1'b1, "R1", irq_n, 1);
        // R2: configuration writes and readback
        step(8'h00, 1, 3'd2, 8'h01, 0, "R2");   // ch0 edge mode
        step(8'h00, 1, 3'd3, 8'h02, 0, "R2");   // ch1 matches high
        step(8'h00, 1, 3'd4, 8'hA5, 0, "R2");
        step(8'h00, 0, 3'd4, 8'h00, 1, "R9");
        chk(vec_out == 8'hA5, "R9", vec_out, 8'hA5);
        step(8'h00, 1, 3'd1, 8'h03, 0, "R2");
        // R3: rising edge on ch0, set at third edge
        step(8'h01, 0, 3'd0, 8'h00, 0, "R3");
        step(8'h01, 0, 3'd0, 8'h00, 0, "R3");
        chk(rd_data[0] == 1'b0, "R3", rd_data[0], 0);
        step(8'h01, 0, 3'd0, 8'h00, 0, "R3");
        chk(rd_data[0] == 1'b1, "R3", rd_data[0], 1);
        chk(irq_n == 1'b0, "R8", irq_n, 0);
        // R6: clear ch0 (no event pending)
        step(8'h01, 1, 3'd0, 8'h01, 0, "R6");
        chk(rd_data[0] == 1'b0, "R6", rd_data[0], 0);
        chk(irq_n == 1'b1, "R8", irq_n, 1);
        // R3/R7: falling edge, clear lands on the event cycle
        step(8'h00, 0, 3'd0, 8'h00, 0, "R3");
        step(8'h00, 0, 3'd0, 8'h00, 0, "R3");
        step(8'h00, 1, 3'd0, 8'h01, 0, "R7");
        chk(rd_data[0] == 1'b1, "R7", rd_data[0], 1);
        step(8'h00, 1, 3'd0, 8'hFE, 0, "R6");   // writing 0 keeps it
        chk(rd_data[0] == 1'b1, "R6", rd_data[0], 1);
        step(8'h00, 1, 3'd0, 8'h01, 0, "R6");
        chk(rd_data[0] == 1'b0, "R6", rd_data[0], 0);
        // R4/R7: level-high ch1 cannot be cleared while matching
        step(8'h02, 0, 3'd0, 8'h00, 0, "R4");
        step(8'h02, 0, 3'd0, 8'h00, 0, "R4");
        step(8'h02, 0, 3'd0, 8'h00, 0, "R4");
        chk(rd_data[1] == 1'b1, "R4", rd_data[1], 1);
        step(8'h02, 1, 3'd0, 8'h02, 0, "R7");
        chk(rd_data[1] == 1'b1, "R7", rd_data[1], 1);
        step(8'h00, 0, 3'd0, 8'h00, 0, "R4");
        step(8'h00, 0, 3'd0, 8'h00, 0, "R4");
        step(8'h00, 1, 3'd0, 8'h02, 0, "R4");
        step(8'h00, 1, 3'd0, 8'h02, 0, "R4");
        chk(rd_data[1] == 1'b0, "R4", rd_data[1], 0);
        // R5: ch3 edge mode but disabled, toggles do nothing
        step(8'h00, 1, 3'd2, 8'h09, 0, "R5");
        for (int i = 0; i < 6; i++) step((i % 2) ? 8'h08 : 8'h00, 0, 3'd0, 8'h00, 0, "R5");
        chk(rd_data[3] == 1'b0, "R5", rd_data[3], 0);
        // R4: ch2 low-level match
        step(8'h00, 1, 3'd1, 8'h04, 0, "R4");
        step(8'h00, 0, 3'd0, 8'h00, 0, "R4");
        chk(rd_data[2] == 1'b1, "R4", rd_data[2], 1);
        chk(irq_n == 1'b0, "R8", irq_n, 0);
        step(8'h00, 1, 3'd1, 8'h00, 0, "R8");   // disable: request drops
        chk(irq_n == 1'b1, "R8", irq_n, 1);
        step(8'h00, 1, 3'd0, 8'hFF, 0, "R6");
        // random phase
        seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic w;
            logic [2:0] a;
            d = NCH'($urandom);
            w = ($urandom % 4) == 0;
            a = 3'($urandom % 5);
            step(d, w, a, NCH'($urandom), 1'($urandom), "R2");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule